// File: doc/BRIEF.md
# Requester-ID to StreamID Translation Table

This block turns the 16-bit requester identity carried by an inbound PCIe transaction into a 6-bit stream identity. An IOMMU and an MSI interrupt translator downstream use that identity. The table has a fixed number of slots. Each slot holds a requester value, a per-bit compare mask, a stream identity, a 3-bit auxiliary tag and a valid flag.

Software never addresses a slot directly. It fills two staging registers and then writes the control register with a slot number. Depending on one control bit, that write either pushes the staging contents into the slot or pulls the slot's contents back into the staging registers.

The lookup side is purely combinational. It reports a hit flag and the stream identity, and it also reports an interrupt-side identity that carries a fixed 2-bit controller code above the stream identity.

Top module: `rid_sid_lut`

## Requirements
- R1: After reset every slot is invalid, the control and both staging registers read 0, and every lookup misses.
- R2: Register addresses are 0 for control, 1 for staging word A and 2 for staging word B. Address 3 reads 0 and ignores writes.
  - Control holds the slot number in bits 4:0 and the fetch bit in bit 16.
  - Staging word A holds valid in bit 31, the tag in bits 10:8 and the stream identity in bits 5:0. Its other bits read 0.
  - Staging word B holds the requester value in bits 31:16 and the mask in bits 15:0.
  - A register write is visible on the read data in the following cycle.
- R3: A control write with bit 16 set copies the selected slot into both staging registers, readable in the following cycle.
- R4: A control write with bit 16 clear stores both staging registers into the selected slot, and lookups use the new contents from the following cycle.
- R5: A slot matches when it is valid and the incoming requester equals the stored requester on every bit whose mask bit is 1. A mask of all ones demands an exact match, and a mask of 0 matches any requester.
- R6: An invalid slot never matches whatever its other fields hold. Storing zero into both staging words and committing frees a slot.
- R7: When several valid slots match, the one with the lowest slot number supplies the stream identity.
- R8: When no slot matches, the hit flag is 0 and the stream identity is 0.
- R9: The interrupt-side identity is the parameter CTRL_ID in bits 7:6 above the stream identity in bits 5:0. The codes are 00 for the first PCIe controller, 01 for the Ethernet controller and 10 for the second PCIe controller.
- R10: Lookup outputs follow the requester input in the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register at reg_addr |
| lk_rid | input | 16 | Requester identity to translate |
| lk_hit | output | 1 | A valid slot matched |
| lk_sid | output | 6 | Stream identity, 0 on a miss |
| lk_msi_id | output | 8 | Controller code above the stream identity |

## Verification
Register writes, fetches and commits take effect at the clock edge that samples the strobe. Their results are therefore due one cycle after the stimulus.

The lookup outputs are due in the same cycle as the requester input, because they depend only on the input and the slot contents. The bench drives inputs shortly after a rising edge and samples at the falling edge. A fetch, commit or register write is seen after exactly one edge, and a lookup is seen before any edge has passed.

A behavioural model advances at each rising edge and is compared at every falling edge. Directed checks sample at the same points.

// File: rtl/rid_sid_lut.sv
module rid_sid_lut #(
  parameter int ENTRIES = 32,
  parameter logic [1:0] CTRL_ID = 2'b00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [15:0] lk_rid,
  output logic        lk_hit,
  output logic [5:0]  lk_sid,
  output logic [7:0]  lk_msi_id
);
  // ENTRIES must be a power of two no larger than 32.
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int SID_W = 6;
  localparam int TAG_W = 3;
  localparam int RID_W = 16;
  localparam int FETCH_BIT = 16;

  logic             e_vld [ENTRIES];
  logic [TAG_W-1:0] e_tag [ENTRIES];
  logic [SID_W-1:0] e_sid [ENTRIES];
  logic [RID_W-1:0] e_rid [ENTRIES];
  logic [RID_W-1:0] e_msk [ENTRIES];

  logic             ctl_fetch;
  logic [IDX_W-1:0] ctl_idx;
  logic             sa_vld;
  logic [TAG_W-1:0] sa_tag;
  logic [SID_W-1:0] sa_sid;
  logic [RID_W-1:0] sb_rid;
  logic [RID_W-1:0] sb_msk;

  wire [IDX_W-1:0] w_idx   = reg_wdata[IDX_W-1:0];
  wire             w_fetch = reg_wdata[FETCH_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_fetch <= 1'b0;
      ctl_idx   <= '0;
      sa_vld    <= 1'b0;
      sa_tag    <= '0;
      sa_sid    <= '0;
      sb_rid    <= '0;
      sb_msk    <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        e_vld[i] <= 1'b0;
        e_tag[i] <= '0;
        e_sid[i] <= '0;
        e_rid[i] <= '0;
        e_msk[i] <= '0;
      end
    end else if (reg_wr) begin
      case (reg_addr)
        2'd0: begin
          ctl_fetch <= w_fetch;
          ctl_idx   <= w_idx;
          if (w_fetch) begin
            sa_vld <= e_vld[w_idx];
            sa_tag <= e_tag[w_idx];
            sa_sid <= e_sid[w_idx];
            sb_rid <= e_rid[w_idx];
            sb_msk <= e_msk[w_idx];
          end else begin
            e_vld[w_idx] <= sa_vld;
            e_tag[w_idx] <= sa_tag;
            e_sid[w_idx] <= sa_sid;
            e_rid[w_idx] <= sb_rid;
            e_msk[w_idx] <= sb_msk;
          end
        end
        2'd1: begin
          sa_vld <= reg_wdata[31];
          sa_tag <= reg_wdata[10:8];
          sa_sid <= reg_wdata[5:0];
        end
        2'd2: begin
          sb_rid <= reg_wdata[31:16];
          sb_msk <= reg_wdata[15:0];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = 32'(ctl_idx) | (32'(ctl_fetch) << FETCH_BIT);
      2'd1:    reg_rdata = {sa_vld, 20'b0, sa_tag, 2'b0, sa_sid};
      2'd2:    reg_rdata = {sb_rid, sb_msk};
      default: reg_rdata = 32'b0;
    endcase
  end

  logic [ENTRIES-1:0] match;
  always_comb begin
    lk_hit = 1'b0;
    lk_sid = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      match[i] = e_vld[i] && (((lk_rid ^ e_rid[i]) & e_msk[i]) == '0);
      if (match[i]) begin
        lk_hit = 1'b1;
        lk_sid = e_sid[i];
      end
    end
  end

  assign lk_msi_id = {CTRL_ID, lk_sid};

  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0 && w_fetch) |=>
      (sa_vld == $past(e_vld[w_idx]) && sa_sid == $past(e_sid[w_idx]) &&
       sb_rid == $past(e_rid[w_idx]) && sb_msk == $past(e_msk[w_idx])));

  p_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0 && !w_fetch) |=>
      (e_vld[$past(w_idx)] == $past(sa_vld) && e_sid[$past(w_idx)] == $past(sa_sid) &&
       e_rid[$past(w_idx)] == $past(sb_rid) && e_msk[$past(w_idx)] == $past(sb_msk)));

  p_miss_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_sid == '0));

  p_hit_needs_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> ($countones(match) > 0));

  p_staging_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> ($stable(sb_rid) && $stable(sb_msk) && $stable(sa_vld)));
endmodule

// File: tb/rid_sid_lut_bench.sv
module rid_sid_lut_bench;
  localparam int N = 32;
  localparam logic [1:0] CID = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic [15:0] lk_rid = 16'd0;
  logic        lk_hit;
  logic [5:0]  lk_sid;
  logic [7:0]  lk_msi_id;

  rid_sid_lut #(.ENTRIES(N), .CTRL_ID(CID)) u_rid_sid_lut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_rid(lk_rid),
    .lk_hit(lk_hit), .lk_sid(lk_sid), .lk_msi_id(lk_msi_id));

  int n_chk = 0;
  int n_fail = 0;
  string req = "R1";
  bit cmp_on = 1'b0;

  bit m_vld [N];
  int m_tag [N];
  int m_sid [N];
  int m_rid [N];
  int m_msk [N];
  bit ma_vld;
  int ma_tag, ma_sid, mb_rid, mb_msk, mc_idx;
  bit mc_fetch;

  always @(posedge clk) begin
    if (!rst_n) begin
      ma_vld = 0; ma_tag = 0; ma_sid = 0; mb_rid = 0; mb_msk = 0;
      mc_idx = 0; mc_fetch = 0;
      for (int i = 0; i < N; i++) begin
        m_vld[i] = 0; m_tag[i] = 0; m_sid[i] = 0; m_rid[i] = 0; m_msk[i] = 0;
      end
    end else if (reg_wr) begin
      if (reg_addr == 2'd0) begin
        int k;
        k = int'(reg_wdata[4:0]);
        mc_idx = k;
        mc_fetch = reg_wdata[16];
        if (mc_fetch) begin
          ma_vld = m_vld[k]; ma_tag = m_tag[k]; ma_sid = m_sid[k];
          mb_rid = m_rid[k]; mb_msk = m_msk[k];
        end else begin
          m_vld[k] = ma_vld; m_tag[k] = ma_tag; m_sid[k] = ma_sid;
          m_rid[k] = mb_rid; m_msk[k] = mb_msk;
        end
      end else if (reg_addr == 2'd1) begin
        ma_vld = reg_wdata[31];
        ma_tag = int'(reg_wdata[10:8]);
        ma_sid = int'(reg_wdata[5:0]);
      end else if (reg_addr == 2'd2) begin
        mb_rid = int'(reg_wdata[31:16]);
        mb_msk = int'(reg_wdata[15:0]);
      end
    end
  end

  function automatic logic [31:0] exp_rdata();
    case (reg_addr)
      2'd0: return (mc_fetch ? 32'h0001_0000 : 32'h0) | 32'(mc_idx);
      2'd1: return (ma_vld ? 32'h8000_0000 : 32'h0) | 32'(ma_tag << 8) | 32'(ma_sid);
      2'd2: return 32'(mb_rid << 16) | 32'(mb_msk);
      default: return 32'h0;
    endcase
  endfunction

  function automatic int exp_sid(output bit hit);
    hit = 0;
    for (int i = 0; i < N; i++)
      if (m_vld[i] && (((int'(lk_rid) ^ m_rid[i]) & m_msk[i]) == 0)) begin
        hit = 1;
        return m_sid[i];
      end
    return 0;
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", r, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      bit h;
      int s;
      s = exp_sid(h);
      chk(req, reg_rdata, exp_rdata(), "model rdata");
      chk(req, 32'(lk_hit), 32'(h), "model hit");
      chk(req, 32'(lk_sid), 32'(s), "model sid");
      chk("R9", 32'(lk_msi_id), 32'({CID, 6'(s)}), "model msi id");
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic wreg(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic commit(input int idx, input logic [31:0] da, input logic [31:0] db);
    wreg(2'd1, da);
    wreg(2'd2, db);
    wreg(2'd0, 32'(idx));
  endtask

  task automatic xlook(input logic [15:0] r, input bit eh, input logic [5:0] es, input string t);
    lk_rid = r;
    #5;
    chk(t, 32'(lk_hit), 32'(eh), "hit");
    chk(t, 32'(lk_sid), 32'(es), "sid");
    step();
  endtask

  task automatic xread(input logic [1:0] a, input logic [31:0] e, input string t);
    reg_addr = a;
    #5;
    chk(t, reg_rdata, e, "rdata");
    step();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1'b1;
    cmp_on = 1'b1;

    req = "R1";
    xread(2'd0, 32'h0, "R1");
    xread(2'd1, 32'h0, "R1");
    xread(2'd2, 32'h0, "R1");
    xlook(16'h0000, 0, 6'h0, "R1");
    xlook(16'hFFFF, 0, 6'h0, "R1");

    req = "R4";
    commit(5, 32'h8000_032A, 32'h0100_FFFF);
    xlook(16'h0100, 1, 6'h2A, "R4");
    lk_rid = 16'h0100;
    #5;
    chk("R9", 32'(lk_msi_id), 32'h0000_00AA, "msi id");
    step();

    req = "R5";
    xlook(16'h0101, 0, 6'h0, "R8");
    commit(3, 32'h8000_0007, 32'h0200_FF00);
    xlook(16'h02FF, 1, 6'h07, "R5");
    xlook(16'h0300, 0, 6'h0, "R8");

    req = "R7";
    commit(1, 32'h8000_0011, 32'h0000_0000);
    xlook(16'h0100, 1, 6'h11, "R7");
    xlook(16'h1234, 1, 6'h11, "R7");

    req = "R6";
    commit(1, 32'h0, 32'h0);
    xlook(16'h0100, 1, 6'h2A, "R6");
    xlook(16'h1234, 0, 6'h0, "R6");
    commit(7, 32'h0000_0515, 32'h7777_FFFF);
    xlook(16'h7777, 0, 6'h0, "R6");

    req = "R7";
    commit(31, 32'h8000_003F, 32'hABCD_FFFF);
    xlook(16'hABCD, 1, 6'h3F, "R5");
    commit(0, 32'h8000_0000, 32'hABCD_FFFF);
    xlook(16'hABCD, 1, 6'h00, "R7");

    req = "R3";
    wreg(2'd0, 32'h0001_0005);
    xread(2'd1, 32'h8000_032A, "R3");
    xread(2'd2, 32'h0100_FFFF, "R3");
    xread(2'd0, 32'h0001_0005, "R2");
    wreg(2'd0, 32'h0001_0001);
    xread(2'd1, 32'h0, "R3");
    xread(2'd2, 32'h0, "R3");

    req = "R2";
    wreg(2'd1, 32'hFFFF_FFFF);
    xread(2'd1, 32'h8000_073F, "R2");
    wreg(2'd3, 32'hDEAD_BEEF);
    xread(2'd3, 32'h0, "R2");
    xread(2'd1, 32'h8000_073F, "R2");

    req = "R10";
    lk_rid = 16'h0200;
    #1;
    chk("R10", 32'(lk_sid), 32'h7, "same-cycle sid");
    lk_rid = 16'h0100;
    #1;
    chk("R10", 32'(lk_sid), 32'h2A, "same-cycle sid");
    step();

    req = "R5";
    for (int n = 0; n < 1500; n++) begin
      int op;
      op = int'($urandom_range(0, 5));
      case (op)
        0: wreg(2'd1, $urandom());
        1: wreg(2'd2, {4'h0, 4'($urandom_range(0, 3)), 8'h00, 16'($urandom())});
        2: wreg(2'd0, 32'($urandom_range(0, N - 1)));
        3: wreg(2'd0, 32'h0001_0000 | 32'($urandom_range(0, N - 1)));
        default: begin
          lk_rid = {4'h0, 4'($urandom_range(0, 3)), 8'($urandom())};
          reg_addr = 2'($urandom_range(0, 3));
          step();
        end
      endcase
    end

    step();
    finish_run();
  end
endmodule